// File: doc/BRIEF.md
# MDIO Management Master with Background PHY Scan

This block is a management-bus master for external Ethernet PHYs. It produces the MDC clock by dividing the system clock, and it runs the MDIO data line through separate output, output-enable and input pins, so that the tri-state buffer sits at the chip pad. Every transaction is a Clause-22 frame of 64 bit times. The frame opens with 32 ones of preamble. Host software reaches the block through four 32-bit words on a simple register bus.

Software starts one PHY register read or write by writing a command word with its start flag set. It then polls that word until the flag drops. For a read, an acknowledge flag shows whether a PHY answered, and the low half of the word carries the data that came back. While the enable bit is set, an autonomous scan engine reads one fixed PHY register from addresses 0 to 31 in turn. It keeps a 32-bit presence map up to date from the acknowledge of each of these reads.

The frame engine is shared by the scan engine and software. When the engine is free, a pending software command always goes first. A command that arrives during a scan read therefore waits for at most that one frame.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control word reads 0x8000_0000 OR'd with the reset divider (idle=1, enable=0). The presence map reads 0, the command word reads 0, and mdio_oe is 0.
- R2: Control word (offset 1): bit 31 is a read-only idle flag, bit 30 is enable, and bits 15:0 are the divider, which accepts values up to 0xFFFF. The MDC period is divider+1 system clocks, and a divider of 0 acts as 1.
- R3: Each frame has 64 bits, sent most significant first: 32 ones, start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, 2 turnaround bits, and 16 data bits. The master changes MDIO only right after MDC falls and samples it on MDC rising.
- R4: On a read, the master drives MDIO for the first 46 bit times only and releases it from the first turnaround bit onward. On a write, it drives all 64 bit times.
- R5: Command word (offset 3): bit 31 start flag, bit 30 write(1)/read(0), bit 29 acknowledge, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. A write with bit 31 set starts a transaction. The start flag reads 1 until the transaction completes and 0 after. A command write with bit 31 clear, or any command write while a transaction is pending, has no effect.
- R6: When a read completes, the acknowledge flag is 1 if the PHY drove the second turnaround bit low, and then bits 15:0 hold the data received. With no PHY, the bus idles high and the flag is 0. A completed write leaves the flag at 0.
- R7: While enabled, the scan engine reads register 1 of PHY addresses 0, 1, ... 31 and then wraps around. Bit n of the presence map (offset 2) holds the acknowledge result of the latest scan of address n.
- R8: A pending command starts before any further scan frame, so it is delayed by at most one scan frame.
- R9: Clearing enable lets the current frame finish and starts no new scan frame. The idle flag reads 0 while a frame is running or waiting to start and 1 otherwise. Commands still run while the block is disabled.
- R10: The version word (offset 0) holds the major revision in bits 15:8 and the minor revision in bits 7:0 (defaults 1 and 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid next cycle |
| reg_addr | input | ADDR_W | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from pad |

## Verification
Assertions check several rules on every cycle. MDIO changes only after an MDC fall, and the master releases the line during the turnaround and data bits of a read. The start flag clears only on a completion, and the idle flag is never 1 while the frame engine is active. A pending command always wins the next slot over a scan, and no scan frame is issued while disabled. Other behaviour can only be shown by the bench scenarios, using a PHY model on the bus: the MDC period for each divider, correct frame fields and returned data, acknowledge and no-acknowledge results, the contents of the presence map after a full scan, the latency bound for a command behind a scan, and the fact that bus activity stops once enable is cleared.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W        = 5;
  localparam int PRE_BITS     = 32;
  localparam int FRAME_BITS   = 64;
  localparam int RD_DRIVE     = 46;
  localparam int ACK_POS      = 47;
  localparam int DATA_POS     = 48;
  localparam int CNT_W        = $clog2(FRAME_BITS);

  localparam int OFS_VER   = 0;
  localparam int OFS_CTRL  = 1;
  localparam int OFS_ALIVE = 2;
  localparam int OFS_CMD   = 3;

  typedef enum logic [1:0] {S_IDLE, S_USER, S_SCAN} sched_t;

  typedef struct packed {
    logic             wr;
    logic [PHY_W-1:0] phy;
    logic [PHY_W-1:0] regad;
    logic [15:0]      data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             fall_tick,
  output logic             rise_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic [DIV_W:0]   span;
  logic [DIV_W:0]   half;
  logic [DIV_W:0]   cnt_nx;

  assign lim       = (div == '0) ? DIV_W'(1) : div;
  assign span      = {1'b0, lim} + 1'b1;
  assign half      = span >> 1;
  assign cnt_nx    = {1'b0, cnt} + 1'b1;
  assign fall_tick = (cnt >= lim);
  assign rise_tick = !fall_tick && (cnt_nx == half);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_tick) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt_nx[DIV_W-1:0];
      if (rise_tick) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fall_tick,
  input  logic        rise_tick,
  input  logic        mdc,
  input  logic        req,
  input  mdio_cmd_t   cmd,
  input  logic        mdi,
  output logic        mdo,
  output logic        oe,
  output logic        active,
  output logic        done,
  output logic        ack,
  output logic [15:0] rdata
);
  logic [FRAME_BITS-1:0] sh;
  logic [FRAME_BITS-1:0] frame_w;
  logic [CNT_W-1:0]      bitcnt;
  logic [CNT_W:0]        bit_nx;
  logic                  is_rd;

  assign frame_w = {{PRE_BITS{1'b1}}, 2'b01,
                    cmd.wr ? 2'b01 : 2'b10,
                    cmd.phy, cmd.regad,
                    cmd.wr ? 2'b10 : 2'b11,
                    cmd.wr ? cmd.data : 16'hFFFF};
  assign bit_nx = {1'b0, bitcnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      bitcnt <= '0;
      is_rd  <= 1'b0;
      active <= 1'b0;
      done   <= 1'b0;
      mdo    <= 1'b1;
      oe     <= 1'b0;
      ack    <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (fall_tick) begin
        if (active) begin
          if (bitcnt == CNT_W'(FRAME_BITS-1)) begin
            active <= 1'b0;
            oe     <= 1'b0;
            mdo    <= 1'b1;
            done   <= 1'b1;
          end else begin
            bitcnt <= bit_nx[CNT_W-1:0];
            sh     <= sh << 1;
            mdo    <= sh[FRAME_BITS-2];
            oe     <= !is_rd || (bit_nx < (CNT_W+1)'(RD_DRIVE));
          end
        end else if (req && !done) begin
          active <= 1'b1;
          bitcnt <= '0;
          sh     <= frame_w;
          mdo    <= frame_w[FRAME_BITS-1];
          oe     <= 1'b1;
          is_rd  <= !cmd.wr;
          ack    <= 1'b0;
        end
      end
      if (rise_tick && active && is_rd) begin
        if (bitcnt == CNT_W'(ACK_POS)) ack <= !mdi;
        if (bitcnt >= CNT_W'(DATA_POS)) rdata <= {rdata[14:0], mdi};
      end
    end
  end

  // R4: line released from first turnaround bit of a read
  p_release_ta_r4: assert property (@(posedge clk) disable iff (rst)
    (active && is_rd && bitcnt >= CNT_W'(RD_DRIVE)) |-> !oe);

  // R3: MDIO output moves only with a falling MDC
  p_mdo_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdo) && !$past(rst)) |-> $fell(mdc));

  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/mdio_sched.sv
module mdio_sched
  import mdio_pkg::*;
#(
  parameter logic [PHY_W-1:0] SCAN_REG = 5'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              user_go,
  input  mdio_cmd_t         user_cmd,
  input  logic              frm_done,
  input  logic              frm_ack,
  output logic              req,
  output mdio_cmd_t         cmd,
  output logic              user_done,
  output logic              idle,
  output logic [(1<<PHY_W)-1:0] alive
);
  sched_t           state;
  logic [PHY_W-1:0] scan_addr;

  assign req       = (state != S_IDLE);
  assign idle      = (state == S_IDLE);
  assign user_done = (state == S_USER) && frm_done;

  always_comb begin
    if (state == S_USER) cmd = user_cmd;
    else begin
      cmd       = '0;
      cmd.phy   = scan_addr;
      cmd.regad = SCAN_REG;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      scan_addr <= '0;
      alive     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (user_go) state <= S_USER;
          else if (en) state <= S_SCAN;
        end
        S_USER: if (frm_done) state <= S_IDLE;
        S_SCAN: begin
          if (frm_done) begin
            alive[scan_addr] <= frm_ack;
            scan_addr        <= scan_addr + 1'b1;
            state            <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: a pending command takes the next free slot
  p_user_first_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && user_go) |=> state == S_USER);

  // R9: no scan issued while disabled
  p_scan_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !en && !user_go) |=> state == S_IDLE);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter int              DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RST  = 16'd63,
  parameter logic [7:0]      VER_MAJOR = 8'd1,
  parameter logic [7:0]      VER_MINOR = 8'd7,
  parameter logic [PHY_W-1:0] SCAN_REG = 5'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ALIVE = ADDR_W'(OFS_ALIVE);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);

  logic             en_q;
  logic [DIV_W-1:0] div_q;
  logic             go_q;
  logic             ack_q;
  mdio_cmd_t        ucmd_q;
  logic             fall_tick, rise_tick;
  logic             frm_req, frm_active, frm_done, frm_ack;
  logic [15:0]      frm_rdata;
  mdio_cmd_t        frm_cmd;
  logic             user_done, sched_idle;
  logic [(1<<PHY_W)-1:0] alive;
  logic             unused_wbits;

  assign unused_wbits = ^{reg_wdata[29:26]};

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div(div_q),
    .mdc(mdc), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  mdio_sched #(.SCAN_REG(SCAN_REG)) u_sched (
    .clk(clk), .rst(rst), .en(en_q), .user_go(go_q), .user_cmd(ucmd_q),
    .frm_done(frm_done), .frm_ack(frm_ack), .req(frm_req), .cmd(frm_cmd),
    .user_done(user_done), .idle(sched_idle), .alive(alive)
  );

  mdio_frame u_frame (
    .clk(clk), .rst(rst), .fall_tick(fall_tick), .rise_tick(rise_tick),
    .mdc(mdc), .req(frm_req), .cmd(frm_cmd), .mdi(mdio_i),
    .mdo(mdio_o), .oe(mdio_oe), .active(frm_active), .done(frm_done),
    .ack(frm_ack), .rdata(frm_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      div_q  <= DIV_RST;
      go_q   <= 1'b0;
      ack_q  <= 1'b0;
      ucmd_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) begin
        en_q  <= reg_wdata[30];
        div_q <= reg_wdata[DIV_W-1:0];
      end
      if (user_done) begin
        go_q <= 1'b0;
        if (!ucmd_q.wr) begin
          ucmd_q.data <= frm_rdata;
          ack_q       <= frm_ack;
        end
      end else if (reg_wr && reg_addr == A_CMD && reg_wdata[31] && !go_q) begin
        go_q         <= 1'b1;
        ack_q        <= 1'b0;
        ucmd_q.wr    <= reg_wdata[30];
        ucmd_q.regad <= reg_wdata[25:21];
        ucmd_q.phy   <= reg_wdata[20:16];
        ucmd_q.data  <= reg_wdata[15:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_VER:   reg_rdata <= {16'h0, VER_MAJOR, VER_MINOR};
        A_CTRL:  reg_rdata <= {sched_idle, en_q, {(30-DIV_W){1'b0}}, div_q};
        A_ALIVE: reg_rdata <= 32'(alive);
        A_CMD:   reg_rdata <= {go_q, ucmd_q.wr, ack_q, 3'b000,
                               ucmd_q.regad, ucmd_q.phy, ucmd_q.data};
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R9: idle never reported while the frame engine runs
  p_idle_vs_active_r9: assert property (@(posedge clk) disable iff (rst)
    frm_active |-> !sched_idle);

  // R5: start flag drops only on a command completion
  p_go_clear_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(go_q) |-> $past(user_done));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_o = 1'b1, phy_oe = 1'b0;

  int nvec = 0, nerr = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign mdio_i = phy_oe ? phy_o : (mdio_oe ? mdio_o : 1'b1);

  mdio_master u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model ----------------
  localparam logic [31:0] PRESENT = 32'h0002_0408; // PHYs 3, 10, 17
  logic [15:0] mem [0:1023];
  logic mdc_prev = 1'b0;
  int ones_run = 0, pos = -1, oe_cnt = 0, last_oe = 0;
  int frames_seen = 0, collisions = 0, last_rise = 0, period = 0;
  logic [12:0] hdr;
  logic [15:0] wsh, rval;
  logic [1:0]  last_op;
  logic [4:0]  last_phy, last_reg;
  bit resp = 0;

  function automatic logic [15:0] dflt(int p, int r);
    return 16'(p * 37 + r * 1021) ^ 16'h5A3C;
  endfunction

  initial for (int i = 0; i < 1024; i++) mem[i] = dflt(i / 32, i % 32);

  always @(negedge clk) begin
    if (phy_oe && mdio_oe) collisions++;
    if (mdc && !mdc_prev) begin
      period = cyc - last_rise;
      last_rise = cyc;
      if (mdio_oe) oe_cnt++;
      if (pos < 0) begin
        if (mdio_i) ones_run++;
        else begin
          if (ones_run >= 32) pos = 32;
          ones_run = 0;
        end
      end else begin
        pos++;
        if (pos <= 45) hdr = {hdr[11:0], mdio_i};
        if (pos == 45) begin
          last_op = hdr[11:10]; last_phy = hdr[9:5]; last_reg = hdr[4:0];
          frames_seen++;
          if (hdr[12] && hdr[11:10] == 2'b10 && PRESENT[hdr[9:5]]) begin
            resp = 1; rval = mem[{hdr[9:5], hdr[4:0]}];
          end
        end
        if (pos >= 48) wsh = {wsh[14:0], mdio_i};
        if (pos == 63) begin
          if (last_op == 2'b01 && PRESENT[last_phy]) mem[{last_phy, last_reg}] = wsh;
          resp = 0; phy_oe = 0; pos = -1;
          last_oe = oe_cnt; oe_cnt = 0;
        end
      end
    end else if (!mdc && mdc_prev && resp) begin
      if (pos + 1 == 47) begin phy_oe = 1; phy_o = 0; end
      else if (pos + 1 >= 48 && pos + 1 <= 63) phy_o = rval[63 - (pos + 1)];
    end
    mdc_prev = mdc;
  end

  // ---------------- helpers ----------------
  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wait_go_clear(output logic [31:0] d);
    d = 32'hFFFF_FFFF;
    for (int k = 0; k < 4000 && d[31]; k++) bus_read(4'd3, d);
  endtask

  function automatic logic [31:0] mkcmd(bit wr, int p, int r, logic [15:0] dat);
    return {1'b1, wr, 1'b0, 3'b000, 5'(r), 5'(p), dat};
  endfunction

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] d;
    bus_read(4'd0, d); check("R10 version", d, 32'h0000_0107);
    bus_read(4'd1, d); check("R1 ctrl reset", d, 32'h8000_003F);
    bus_read(4'd2, d); check("R1 alive reset", d, 0);
    bus_read(4'd3, d); check("R1 cmd reset", d, 0);
    check("R1 oe reset", 32'(mdio_oe), 0);
  endtask

  task automatic t_divider();
    logic [31:0] d;
    bus_write(4'd1, 32'h0000_FFFF);
    bus_read(4'd1, d); check("R2 div max readback", d, 32'h8000_FFFF);
    bus_write(4'd1, 32'd7); repeat (40) @(negedge clk);
    check("R2 period div7", period, 8);
    bus_write(4'd1, 32'd3); repeat (20) @(negedge clk);
    check("R2 period div3", period, 4);
    bus_write(4'd1, 32'd0); repeat (20) @(negedge clk);
    check("R2 period div0", period, 2);
    bus_write(4'd1, 32'd7);
  endtask

  task automatic t_read_present();
    logic [31:0] d;
    bus_write(4'd3, mkcmd(0, 3, 2, 16'h0));
    bus_read(4'd3, d); check("R5 go pending", 32'(d[31]), 1);
    wait_go_clear(d);
    check("R6 read ack+data", d, {3'b001, 3'b000, 5'd2, 5'd3, dflt(3, 2)});
    check("R4 read oe bits", last_oe, 46);
    check("R3 opcode read", 32'(last_op), 2);
    check("R3 phy/reg fields", {last_phy, last_reg}, {5'd3, 5'd2});
  endtask

  task automatic t_read_absent();
    logic [31:0] d;
    bus_write(4'd3, mkcmd(0, 5, 9, 16'h0));
    wait_go_clear(d);
    check("R6 no ack", d, {3'b000, 3'b000, 5'd9, 5'd5, 16'hFFFF});
  endtask

  task automatic t_write();
    logic [31:0] d;
    bus_write(4'd3, mkcmd(1, 10, 4, 16'h1234));
    wait_go_clear(d);
    check("R6 write ack clear", d, {3'b010, 3'b000, 5'd4, 5'd10, 16'h1234});
    check("R4 write oe bits", last_oe, 64);
    check("R3 opcode write", 32'(last_op), 1);
    bus_write(4'd3, mkcmd(0, 10, 4, 16'h0));
    wait_go_clear(d);
    check("R3 written data read back", d, {3'b001, 3'b000, 5'd4, 5'd10, 16'h1234});
    check("R4 no bus collision", collisions, 0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    bus_write(4'd3, mkcmd(0, 3, 7, 16'h0));
    bus_write(4'd3, mkcmd(1, 17, 9, 16'hBEEF));
    wait_go_clear(d);
    check("R5 write while pending ignored", d, {3'b001, 3'b000, 5'd7, 5'd3, dflt(3, 7)});
    bus_write(4'd3, {1'b0, 1'b1, 1'b0, 3'b000, 5'd1, 5'd1, 16'h5555});
    repeat (300) @(negedge clk);
    bus_read(4'd3, d);
    check("R5 go=0 write ignored", d, {3'b001, 3'b000, 5'd7, 5'd3, dflt(3, 7)});
  endtask

  task automatic t_scan();
    logic [31:0] d;
    bus_write(4'd1, 32'h4000_0001);
    repeat (34 * 140) @(negedge clk);
    bus_read(4'd2, d); check("R7 presence map", d, PRESENT);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    int t0;
    t0 = cyc;
    bus_write(4'd3, mkcmd(0, 17, 0, 16'h0));
    wait_go_clear(d);
    check("R8 data behind scan", d, {3'b001, 3'b000, 5'd0, 5'd17, dflt(17, 0)});
    check("R8 latency bound", 32'((cyc - t0) <= 300), 1);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    int f0;
    for (int k = 0; k < 400 && !mdio_oe; k++) @(negedge clk);
    bus_write(4'd1, 32'h0000_0001);
    bus_read(4'd1, d); check("R9 busy while frame runs", d, 32'h0000_0001);
    repeat (200) @(negedge clk);
    bus_read(4'd1, d); check("R9 idle after stop", d, 32'h8000_0001);
    f0 = frames_seen;
    repeat (600) @(negedge clk);
    check("R9 no frames when disabled", frames_seen - f0, 0);
    bus_read(4'd2, d); check("R7 map kept", d, PRESENT);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_divider();
    t_read_present();
    t_read_absent();
    t_write();
    t_ignored();
    t_scan();
    t_arb();
    t_disable();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule